// File: doc/BRIEF.md
# Handshake-Paced Backplane Slave Responder

This block is the slave side of an asynchronous backplane bus on which every transfer is paced by strobes and an acknowledge rather than by a clock. It watches the address strobe, two byte-lane data strobes, the address lines, a six-bit modifier code, a long-word qualifier, an interrupt-acknowledge qualifier and the write line. It passes every strobe through a two-flop synchroniser into its own unrelated clock. When the synchronised address strobe falls, it latches the address and qualifiers. The modifier code then picks the address space (16, 24 or 32 significant address bits) and the base address that the cycle must hit.

On a hit, each data-strobe phase moves 8, 16 or 32 bits between the bus and a small local register file. The block then pulls the acknowledge low and holds it until both data strobes have been released. Several data phases may run under one address strobe, which forms an indivisible read-modify-write on the latched location. An address strobe with no data strobe is an address-only cycle and is never acknowledged. Read data is driven, with its output enable high, only while the acknowledge of a read is asserted.

Top module: `asr_slave`

## Requirements
- R1: After reset the acknowledge output is high (released) and the read-data output enable is low.
- R2: A cycle is selected only when the modifier code equals one of three parameter codes (default 0x29 for 16-bit space, 0x39 for 24-bit space, 0x09 for 32-bit space). Address bits above the register window, and within that space's width, must equal the space's base (defaults 0x0000_1000, 0x0020_0000, 0x8000_0000). Address bits above the space's width are ignored. Any other code or address gets no acknowledge and no write.
- R3: With the long-word qualifier low and both data strobes active, a write stores all 32 bus data bits into register addr[4:2], and a read returns that whole register on the data bus.
- R4: With the long-word qualifier high, the data travels on bus bits 15:0. Address bit 1 = 0 selects register bits 31:16 and address bit 1 = 1 selects bits 15:0. Data strobe 1 enables the upper byte of that half and data strobe 0 the lower byte. A read returns the selected half on bits 15:0 with bits 31:16 zero.
- R5: The acknowledge stays low until both data strobes are seen released, and the output enable is high only while a read is acknowledged.
- R6: The address is latched once per address strobe. A second data phase under the same address strobe (read-modify-write) uses the first address even if the address lines have changed.
- R7: An address strobe with no data strobe produces no acknowledge.
- R8: A cycle with the interrupt-acknowledge qualifier low is ignored: no acknowledge and no write.
- R9: A long-word cycle with only one data strobe active is not acknowledged and writes nothing.
- R10: Data strobes that become active up to one local clock apart are treated as one transfer of the combined width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, unrelated to bus timing |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_astb_n | input | 1 | Address strobe, active low |
| bus_dstb_n | input | 2 | Data strobes, active low; bit 1 upper byte, bit 0 lower byte |
| bus_addr | input | 31 | Address lines, bits 31 down to 1 |
| bus_mod | input | 6 | Address modifier code |
| bus_long_n | input | 1 | Long-word qualifier, active low |
| bus_intack_n | input | 1 | Interrupt-acknowledge qualifier, active low |
| bus_wr_n | input | 1 | Low for write, high for read |
| bus_din | input | 32 | Write data from the bus |
| bus_dout | output | 32 | Read data to the bus |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_ack_n | output | 1 | Data acknowledge, active low |

## Verification
The bench aims at the places where a responder most often goes wrong. It changes the address lines between the two halves of a read-modify-write; a design that re-latched them would write the wrong register. It releases one data strobe while holding the other; early release of the acknowledge would let the master end the cycle while part of the bus is still driven. It staggers the two strobes by a clock; a design sampling on the first strobe alone would size the cycle as one byte and ignore it as a bad long-word. Address-only, interrupt-acknowledge, single-strobe long-word and foreign-modifier cycles are each followed by a read-back, so a stray acknowledge or write shows up at the ports.

// File: rtl/asr_pkg.sv
package asr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_LANE,
      ST_ACK,
      ST_SKIP
   } asr_state_t;

   localparam int ASR_DW = 32;
   localparam int ASR_MODW = 6;
endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
   parameter int W = 4,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   initial begin : prm_chk
      assert (W >= 1) else $error("asr_sync: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= RST_VAL;
         q    <= RST_VAL;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/asr_decode.sv
module asr_decode #(
   parameter int IDX_W = 3,
   parameter logic [5:0] MOD16 = 6'h29,
   parameter logic [5:0] MOD24 = 6'h39,
   parameter logic [5:0] MOD32 = 6'h09,
   parameter logic [31:0] BASE16 = 32'h0000_1000,
   parameter logic [31:0] BASE24 = 32'h0020_0000,
   parameter logic [31:0] BASE32 = 32'h8000_0000
) (
   input  logic [5:0]       mod,
   input  logic [31:1]      addr,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   localparam int LOW = IDX_W + 2;
   localparam logic [31:0] WIN = (32'h1 << LOW) - 32'h1;
   localparam logic [3*6-1:0] CODES = {MOD32, MOD24, MOD16};
   localparam logic [3*32-1:0] SPAN = {32'hFFFF_FFFF, 32'h00FF_FFFF, 32'h0000_FFFF};
   localparam logic [3*32-1:0] BASES = {BASE32, BASE24, BASE16};

   initial begin : prm_chk
      assert (IDX_W >= 1 && LOW < 16) else $error("asr_decode: window width out of range");
      assert ((BASE16 & ~32'h0000_FFFF) == 32'h0) else $error("asr_decode: BASE16 exceeds 16-bit space");
      assert ((BASE24 & ~32'h00FF_FFFF) == 32'h0) else $error("asr_decode: BASE24 exceeds 24-bit space");
      assert (MOD16 != MOD24 && MOD24 != MOD32 && MOD16 != MOD32) else $error("asr_decode: codes must differ");
   end

   logic [31:0] full_addr;
   logic [2:0]  sp_hit;

   assign full_addr = {addr, 1'b0};

   for (genvar g = 0; g < 3; g++) begin : g_space
      localparam logic [31:0] CMP = SPAN[g*32 +: 32] & ~WIN;
      assign sp_hit[g] = (mod == CODES[g*6 +: 6]) &&
                         ((full_addr & CMP) == (BASES[g*32 +: 32] & CMP));
   end

   assign hit = |sp_hit;
   assign idx = full_addr[LOW-1:2];
endmodule

// File: rtl/asr_regfile.sv
module asr_regfile #(
   parameter int NREG  = 8,
   parameter int IDX_W = 3,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW/8-1:0]  be,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   localparam int NB = DW / 8;

   initial begin : prm_chk
      assert (DW % 8 == 0) else $error("asr_regfile: DW must be a byte multiple");
      assert (NREG == (1 << IDX_W)) else $error("asr_regfile: NREG must equal 2**IDX_W");
   end

   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic [7:0] lane_mem [NREG];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int r = 0; r < NREG; r++) lane_mem[r] <= 8'h00;
         end else if (we && be[b]) begin
            lane_mem[idx] <= wdata[b*8 +: 8];
         end
      end

      assign rdata[b*8 +: 8] = lane_mem[idx];
   end

   AST_WE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (be != '0)); // R4
endmodule

// File: rtl/asr_slave.sv
module asr_slave
   import asr_pkg::*;
#(
   parameter int NREG = 8,
   parameter logic [5:0] MOD16 = 6'h29,
   parameter logic [5:0] MOD24 = 6'h39,
   parameter logic [5:0] MOD32 = 6'h09,
   parameter logic [31:0] BASE16 = 32'h0000_1000,
   parameter logic [31:0] BASE24 = 32'h0020_0000,
   parameter logic [31:0] BASE32 = 32'h8000_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_astb_n,
   input  logic [1:0]  bus_dstb_n,
   input  logic [31:1] bus_addr,
   input  logic [5:0]  bus_mod,
   input  logic        bus_long_n,
   input  logic        bus_intack_n,
   input  logic        bus_wr_n,
   input  logic [31:0] bus_din,
   output logic [31:0] bus_dout,
   output logic        bus_doe,
   output logic        bus_ack_n
);
   localparam int IDX_W = $clog2(NREG);
   localparam int NB = ASR_DW / 8;

   initial begin : prm_chk
      assert (NREG >= 2 && NREG <= 256) else $error("asr_slave: NREG out of range");
      assert (NREG == (1 << IDX_W)) else $error("asr_slave: NREG must be a power of two");
   end

   // synchronised strobes and write line
   logic [3:0] sync_q;
   logic       as_s, wr_s, as_prev;
   logic [1:0] ds_s;

   asr_sync #(.W(4), .RST_VAL(4'b1111)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_astb_n, bus_dstb_n, bus_wr_n}),
      .q     (sync_q)
   );
   assign {as_s, ds_s, wr_s} = sync_q;

   // address phase latch
   logic [31:1]         adr_q;
   logic [5:0]          mod_q;
   logic                long_q, intack_q;
   logic                as_fall;
   asr_state_t          st, nxt;

   assign as_fall = as_prev && !as_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_prev  <= 1'b1;
         adr_q    <= '0;
         mod_q    <= '0;
         long_q   <= 1'b0;
         intack_q <= 1'b0;
      end else begin
         as_prev <= as_s;
         if (st == ST_IDLE && as_fall) begin
            adr_q    <= bus_addr;
            mod_q    <= bus_mod;
            long_q   <= !bus_long_n;
            intack_q <= !bus_intack_n;
         end
      end
   end

   logic             hit;
   logic [IDX_W-1:0] idx;

   asr_decode #(
      .IDX_W (IDX_W), .MOD16 (MOD16), .MOD24 (MOD24), .MOD32 (MOD32),
      .BASE16 (BASE16), .BASE24 (BASE24), .BASE32 (BASE32)
   ) i_dec (
      .mod  (mod_q),
      .addr (adr_q),
      .hit  (hit),
      .idx  (idx)
   );

   // lane and size selection
   logic [1:0]        lanes;
   logic              size_ok, xfer, we;
   logic [NB-1:0]     be;
   logic [31:0]       wdata, rdata, rd_fmt;

   assign lanes   = ~ds_s;
   assign size_ok = long_q ? (lanes == 2'b11) : (lanes != 2'b00);
   assign xfer    = (st == ST_LANE) && size_ok;
   assign we      = xfer && !wr_s;

   always_comb begin
      if (long_q) begin
         be     = '1;
         wdata  = bus_din;
         rd_fmt = rdata;
      end else begin
         be     = adr_q[1] ? {2'b00, lanes} : {lanes, 2'b00};
         wdata  = {bus_din[15:0], bus_din[15:0]};
         rd_fmt = {16'h0000, adr_q[1] ? rdata[15:0] : rdata[31:16]};
      end
   end

   asr_regfile #(.NREG(NREG), .IDX_W(IDX_W), .DW(ASR_DW)) i_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .idx   (idx),
      .be    (be),
      .wdata (wdata),
      .rdata (rdata)
   );

   // handshake state machine
   always_comb begin
      nxt = st;
      case (st)
         ST_IDLE: if (as_fall) nxt = ST_SEL;
         ST_SEL: begin
            if (as_s) nxt = ST_IDLE;
            else if (hit && !intack_q && ds_s != 2'b11) nxt = ST_LANE;
         end
         ST_LANE: begin
            if (lanes == 2'b00) nxt = ST_SEL;
            else if (size_ok)   nxt = ST_ACK;
            else                nxt = ST_SKIP;
         end
         ST_ACK:  if (ds_s == 2'b11) nxt = ST_SEL;
         ST_SKIP: if (ds_s == 2'b11) nxt = ST_SEL;
         default: nxt = ST_IDLE;
      endcase
   end

   logic        rd_cyc_q;
   logic [31:0] rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         rd_cyc_q <= 1'b0;
         rd_q     <= '0;
      end else begin
         st <= nxt;
         if (xfer) begin
            rd_cyc_q <= wr_s;
            rd_q     <= wr_s ? rd_fmt : 32'h0;
         end
      end
   end

   assign bus_ack_n = (st != ST_ACK);
   assign bus_doe   = (st == ST_ACK) && rd_cyc_q;
   assign bus_dout  = rd_q;

   AST_OE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      bus_doe |-> !bus_ack_n); // R5
   AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ack_n && ds_s != 2'b11) |=> !bus_ack_n); // R5
   AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(adr_q)); // R6
   AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_ack_n) |-> (ds_s != 2'b11)); // R7
   AST_INTACK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && intack_q) |-> bus_ack_n); // R8
   AST_LONG_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_ack_n) && long_q) |-> ($past(lanes) == 2'b11)); // R9
endmodule

// File: tb/test_asr_slave.sv
module test_asr_slave;
   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] M16 = 6'h29, M24 = 6'h39, M32 = 6'h09;

   typedef struct packed {
      logic [5:0]  mod;
      logic [31:0] addr;
      logic        lng;
      logic [1:0]  ds;
      logic        wr;
      logic [31:0] wdata;
      logic        ack;
      logic [31:0] rdata;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{M32,   32'h8000_0004, 1'b1, 2'b11, 1'b1, 32'hDEAD_BEEF, 1'b1, 32'h0},          // R3
      '{M32,   32'h8000_0004, 1'b1, 2'b11, 1'b0, 32'h0,         1'b1, 32'hDEAD_BEEF}, // R3
      '{M24,   32'h0020_0004, 1'b0, 2'b11, 1'b1, 32'h0000_1234, 1'b1, 32'h0},          // R4
      '{M16,   32'h0000_1006, 1'b0, 2'b01, 1'b1, 32'h0000_0055, 1'b1, 32'h0},          // R4
      '{M32,   32'h8000_0004, 1'b1, 2'b11, 1'b0, 32'h0,         1'b1, 32'h1234_BE55}, // R4
      '{M16,   32'h0000_1006, 1'b0, 2'b11, 1'b0, 32'h0,         1'b1, 32'h0000_BE55}, // R4
      '{M24,   32'h0020_0004, 1'b0, 2'b10, 1'b0, 32'h0,         1'b1, 32'h0000_1234}, // R4
      '{6'h3F, 32'h8000_0004, 1'b1, 2'b11, 1'b1, 32'h0,         1'b0, 32'h0},          // R2
      '{M32,   32'h9000_0004, 1'b1, 2'b11, 1'b1, 32'h0,         1'b0, 32'h0},          // R2
      '{M16,   32'h0000_2004, 1'b1, 2'b11, 1'b1, 32'h0,         1'b0, 32'h0},          // R2
      '{M24,   32'h5520_0008, 1'b1, 2'b11, 1'b1, 32'hA5A5_0F0F, 1'b1, 32'h0},          // R2
      '{M32,   32'h8000_0008, 1'b1, 2'b11, 1'b0, 32'h0,         1'b1, 32'hA5A5_0F0F}, // R2
      '{M32,   32'h8000_0004, 1'b1, 2'b11, 1'b0, 32'h0,         1'b1, 32'h1234_BE55}  // R2
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_astb_n = 1'b1;
   logic [1:0]  bus_dstb_n = 2'b11;
   logic [31:1] bus_addr = '0;
   logic [5:0]  bus_mod = '0;
   logic        bus_long_n = 1'b1;
   logic        bus_intack_n = 1'b1;
   logic        bus_wr_n = 1'b1;
   logic [31:0] bus_din = '0;
   logic [31:0] bus_dout;
   logic        bus_doe;
   logic        bus_ack_n;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   asr_slave i_asr_slave (
      .clk (clk), .rst_n (rst_n), .bus_astb_n (bus_astb_n), .bus_dstb_n (bus_dstb_n),
      .bus_addr (bus_addr), .bus_mod (bus_mod), .bus_long_n (bus_long_n),
      .bus_intack_n (bus_intack_n), .bus_wr_n (bus_wr_n), .bus_din (bus_din),
      .bus_dout (bus_dout), .bus_doe (bus_doe), .bus_ack_n (bus_ack_n)
   );

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic wait_ack(output logic seen, output logic [31:0] rd);
      seen = 1'b0;
      rd = 32'hFFFF_FFFF;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!bus_ack_n) begin
            seen = 1'b1;
            if (bus_doe) rd = bus_dout;
            break;
         end
      end
   endtask

   task automatic wait_release();
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (bus_ack_n) break;
      end
      check(bus_ack_n && !bus_doe, "R5 ack and enable released after strobes", {30'h0, bus_doe, bus_ack_n}, 32'h1);
   endtask

   task automatic addr_phase(input logic [5:0] mod, input logic [31:0] addr, input logic lng, input logic intack);
      @(negedge clk);
      bus_addr = addr[31:1];
      bus_mod = mod;
      bus_long_n = !lng;
      bus_intack_n = !intack;
      @(negedge clk);
      bus_astb_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic end_cycle();
      bus_astb_n = 1'b1;
      bus_wr_n = 1'b1;
      bus_intack_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_cycle(input logic [5:0] mod, input logic [31:0] addr, input logic lng,
                            input logic intack, input logic [1:0] ds, input logic wr,
                            input logic [31:0] wdata, input logic skew,
                            output logic acked, output logic [31:0] rd);
      addr_phase(mod, addr, lng, intack);
      bus_wr_n = !wr;
      bus_din = wr ? wdata : 32'h0;
      @(negedge clk);
      if (skew) begin
         bus_dstb_n[1] = !ds[1];
         @(negedge clk);
         bus_dstb_n[0] = !ds[0];
      end else begin
         bus_dstb_n = ~ds;
      end
      wait_ack(acked, rd);
      bus_dstb_n = 2'b11;
      if (acked) wait_release();
      else repeat (3) @(negedge clk);
      end_cycle();
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin : stim
      logic acked;
      logic [31:0] rd;
      int low_cnt;

      repeat (3) @(negedge clk);
      check(bus_ack_n && !bus_doe, "R1 reset outputs", {30'h0, bus_doe, bus_ack_n}, 32'h1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(bus_ack_n && !bus_doe, "R1 idle outputs after reset", {30'h0, bus_doe, bus_ack_n}, 32'h1);

      // vector table walk
      for (int v = 0; v < NV; v++) begin
         bus_cycle(VECS[v].mod, VECS[v].addr, VECS[v].lng, 1'b0, VECS[v].ds, VECS[v].wr,
                   VECS[v].wdata, 1'b0, acked, rd);
         check(acked == VECS[v].ack, $sformatf("R2 vector %0d acknowledge", v), {31'h0, acked}, {31'h0, VECS[v].ack});
         if (VECS[v].ack && !VECS[v].wr)
            check(rd == VECS[v].rdata, $sformatf("R3 R4 vector %0d read data", v), rd, VECS[v].rdata);
      end

      // R7 address-only cycle
      addr_phase(M32, 32'h8000_0004, 1'b1, 1'b0);
      low_cnt = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (!bus_ack_n) low_cnt++;
      end
      end_cycle();
      check(low_cnt == 0, "R7 address-only cycle not acknowledged", low_cnt, 0);

      // R8 interrupt-acknowledge qualifier ignored
      bus_cycle(M32, 32'h8000_0004, 1'b1, 1'b1, 2'b11, 1'b1, 32'hFFFF_0000, 1'b0, acked, rd);
      check(!acked, "R8 no ack with intack qualifier", {31'h0, acked}, 32'h0);
      bus_cycle(M32, 32'h8000_0004, 1'b1, 1'b0, 2'b11, 1'b0, 32'h0, 1'b0, acked, rd);
      check(rd == 32'h1234_BE55, "R8 register unchanged", rd, 32'h1234_BE55);

      // R9 long-word with one strobe
      bus_cycle(M32, 32'h8000_0004, 1'b1, 1'b0, 2'b01, 1'b1, 32'h0BAD_0BAD, 1'b0, acked, rd);
      check(!acked, "R9 single-strobe long not acknowledged", {31'h0, acked}, 32'h0);
      bus_cycle(M32, 32'h8000_0004, 1'b1, 1'b0, 2'b11, 1'b0, 32'h0, 1'b0, acked, rd);
      check(rd == 32'h1234_BE55, "R9 register unchanged", rd, 32'h1234_BE55);

      // R10 staggered strobes
      bus_cycle(M32, 32'h8000_0014, 1'b1, 1'b0, 2'b11, 1'b1, 32'hCAFE_F00D, 1'b1, acked, rd);
      check(acked, "R10 staggered long write acknowledged", {31'h0, acked}, 32'h1);
      bus_cycle(M32, 32'h8000_0014, 1'b1, 1'b0, 2'b11, 1'b0, 32'h0, 1'b0, acked, rd);
      check(rd == 32'hCAFE_F00D, "R10 staggered write stored all lanes", rd, 32'hCAFE_F00D);

      // R6 read-modify-write with address lines changed between phases
      addr_phase(M32, 32'h8000_000C, 1'b1, 1'b0);
      bus_wr_n = 1'b1;
      @(negedge clk);
      bus_dstb_n = 2'b00;
      wait_ack(acked, rd);
      check(acked && rd == 32'h0, "R6 read phase of rmw", rd, 32'h0);
      bus_dstb_n = 2'b11;
      wait_release();
      bus_addr = 31'h4000_0008;
      bus_wr_n = 1'b0;
      bus_din = 32'h1111_2222;
      @(negedge clk);
      bus_dstb_n = 2'b00;
      wait_ack(acked, rd);
      check(acked, "R6 write phase of rmw acknowledged", {31'h0, acked}, 32'h1);
      bus_dstb_n = 2'b11;
      wait_release();
      end_cycle();
      bus_cycle(M32, 32'h8000_000C, 1'b1, 1'b0, 2'b11, 1'b0, 32'h0, 1'b0, acked, rd);
      check(rd == 32'h1111_2222, "R6 rmw wrote latched address", rd, 32'h1111_2222);
      bus_cycle(M32, 32'h8000_0010, 1'b1, 1'b0, 2'b11, 1'b0, 32'h0, 1'b0, acked, rd);
      check(rd == 32'h0, "R6 new address lines not written", rd, 32'h0);

      // R5 acknowledge held while one strobe remains active
      addr_phase(M32, 32'h8000_0004, 1'b1, 1'b0);
      bus_wr_n = 1'b1;
      @(negedge clk);
      bus_dstb_n = 2'b00;
      wait_ack(acked, rd);
      check(acked && rd == 32'h1234_BE55, "R5 read acknowledged with data", rd, 32'h1234_BE55);
      bus_dstb_n = 2'b01;
      low_cnt = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!bus_ack_n && bus_doe) low_cnt++;
      end
      check(low_cnt == 6, "R5 ack and enable held with one strobe active", low_cnt, 6);
      bus_dstb_n = 2'b11;
      wait_release();
      end_cycle();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule